// File: doc/BRIEF.md
# Comparator Hit Detector

This block turns the raw outputs of a bank of threshold comparators into one hit bit per channel per clock cycle, ready to be written straight into a latency pipeline memory. The comparator outputs are asynchronous to the system clock. Each channel passes through identical logic. A single configuration bit, shared by all channels, selects one of two ways of forming the hit.

In level mode, each comparator output is brought into the clock domain by a synchroniser chain, and the synchronised level becomes the hit bit. A wide pulse therefore spans several hit cycles. A pulse that falls entirely between two sampling edges is not seen. In single-shot mode, the rising edge of each comparator pulse sets a per-channel capture flop that is not clocked by the system clock. Its synchronised output yields exactly one hit cycle for that pulse. Pulses shorter than a clock period are stretched to that one cycle, and pulses longer than a clock period are compressed to it. Once the hit has been issued, the capture flop is cleared. A pulse that stays high cannot retrigger, because only a new rising edge sets the capture flop again.

Both modes have the same latency of three rising clock edges from input to hit. The mode bit is meant to be static. Any change of the mode bit, and any time spent in level mode, keeps the capture flops cleared, so no stale pulse leaks into the hit stream.

Top module: `hit_detect`

## Requirements
- R1: While `rst` is high, and after it falls until a new comparator edge arrives, every bit of `hit` is 0, whatever `comp` does during reset.
- R2: With `mode` = 1 (level mode), `hit[i]` after a rising clock edge equals the value of `comp[i]` sampled at the rising edge two cycles earlier. A pulse covering n sampling edges gives n consecutive hit cycles, the first of them after the third edge.
- R3: With `mode` = 1, a comparator pulse that covers no rising clock edge produces no hit.
- R4: With `mode` = 0 (single-shot mode), every rising edge of `comp[i]`, including pulses far shorter than a clock period, produces exactly one hit cycle on `hit[i]`. That hit is high after the third rising clock edge following the comparator edge.
- R5: With `mode` = 0, a comparator pulse lasting many clock periods still produces exactly one hit cycle. No further hit follows while the input stays high.
- R6: Channels are independent. A pulse on one channel never produces a hit on another, and simultaneous pulses on all channels hit in the same cycle.
- R7: While in level mode, and on any change of `mode`, all pending captured pulses are discarded. After returning to single-shot mode, no stale hit appears, and a new pulse on the same channel is still detected.
- R8: In single-shot mode, two pulses on one channel whose rising edges are at least 6 clock cycles apart produce two separate hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 = single-shot hit per pulse, 1 = synchronised level |
| comp | input | N_CH | Asynchronous comparator outputs, one per channel |
| hit | output | N_CH | Registered hit bits, one per channel per clock |

## Verification
A table of pulses is applied, each varying the mode, the channel, the offset of the pulse within the clock period and its width, from a 2 ns sliver to several clock periods. The offset and width are chosen so that a pulse either straddles or misses a sampling edge. This separates level mode, where hit count tracks the number of sampling edges covered, from single-shot mode, where the count is always one and the first hit is fixed at the third edge. Directed cases fire all channels at once to expose cross-channel mixing, send a repeated pulse on one channel to check the dead time, and switch the mode with a capture pending. The last case shows whether the discarded pulse leaks out as a stale hit or blocks the next real pulse.

// File: rtl/hitdet_pkg.sv
package hitdet_pkg;
  typedef enum logic {
    MODE_SHOT  = 1'b0,
    MODE_LEVEL = 1'b1
  } hit_mode_e;
endpackage

// File: rtl/hitdet_sync.sv
// Multi-stage synchroniser bank, synchronous active-high reset.
module hitdet_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hitdet_catch.sv
// Per-channel edge capture: the comparator edge sets the flop, a registered
// clear empties it.
module hitdet_catch #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] comp,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] flag
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_ch
    logic held;
    always_ff @(posedge comp[i] or posedge clr[i]) begin
      if (clr[i]) held <= 1'b0;
      else        held <= 1'b1;
    end
    assign flag[i] = held;
  end
endmodule

// File: rtl/hitdet_rise.sv
// Rising-edge detector on the synchronised capture flags.
module hitdet_rise #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/hit_detect.sv
module hit_detect
  import hitdet_pkg::*;
#(
  parameter int N_CH        = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode,
  input  logic [N_CH-1:0] comp,
  output logic [N_CH-1:0] hit
);
  localparam logic [N_CH-1:0] ALL_ONES = {N_CH{1'b1}};

  hit_mode_e       mode_q;
  logic            mode_chg;
  logic [N_CH-1:0] clear_q;
  logic [N_CH-1:0] flag;
  logic [N_CH-1:0] flag_sync;
  logic [N_CH-1:0] level_sync;
  logic [N_CH-1:0] shot;

  assign mode_chg = (hit_mode_e'(mode) != mode_q);

  hitdet_catch #(.WIDTH(N_CH)) u_catch (
    .comp (comp),
    .clr  (clear_q),
    .flag (flag)
  );

  hitdet_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_flag_sync (
    .clk (clk),
    .rst (rst),
    .d   (flag),
    .q   (flag_sync)
  );

  hitdet_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_level_sync (
    .clk (clk),
    .rst (rst),
    .d   (comp),
    .q   (level_sync)
  );

  hitdet_rise #(.WIDTH(N_CH)) u_rise (
    .clk  (clk),
    .rst  (rst),
    .lvl  (flag_sync),
    .rise (shot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_SHOT;
      clear_q <= ALL_ONES;
      hit     <= '0;
    end else begin
      mode_q <= hit_mode_e'(mode);
      if (mode_q == MODE_LEVEL || mode_chg) clear_q <= ALL_ONES;
      else                                  clear_q <= flag_sync;
      if (mode_q == MODE_LEVEL) hit <= level_sync;
      else                      hit <= shot;
    end
  end
endmodule

// File: rtl/hit_detect_checker.sv
module hit_detect_checker #(
  parameter int N_CH        = 128,
  parameter int SYNC_STAGES = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            mode,
  input logic [N_CH-1:0] comp,
  input logic [N_CH-1:0] hit,
  input logic [N_CH-1:0] clear_q
);
  // R1: reset forces the hit bits low
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (hit == '0));

  // R4 and R5: single-shot hits never last two cycles
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (!$past(mode) && !$past(mode, 2) && !$past(rst))
      |-> ((hit & $past(hit)) == '0));

  // R7: a mode change discards pending captures
  a_r7_mode_change_clear: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |=> (clear_q == {N_CH{1'b1}}));

  // R7: level mode keeps the capture flops cleared
  a_r7_level_holds_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) && !$past(rst)) |=> (clear_q == {N_CH{1'b1}}));

  if (SYNC_STAGES == 2) begin : g_lvl
    // R2: level mode is the comparator sampled three edges back
    a_r2_level_copy: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && !$past(rst, 4) &&
       $past(mode, 2) && $past(mode, 3))
        |-> (hit == $past(comp, 3)));
  end
endmodule

bind hit_detect hit_detect_checker #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) i_hit_detect_checker (
  .clk     (clk),
  .rst     (rst),
  .mode    (mode),
  .comp    (comp),
  .hit     (hit),
  .clear_q (clear_q)
);

// File: tb/test_hit_detect.sv
`timescale 1ns/1ps
module test_hit_detect;
  localparam int NCH = 8;
  localparam int NV  = 8;
  // columns: mode, channel, offset ns, width ns, expected count, expected first sample, requirement
  localparam int VEC [NV][7] = '{
    '{0, 0, 5,   2, 1, 3, 4},  // R4 stretch a sliver
    '{0, 5, 3, 100, 1, 3, 5},  // R5 compress a long pulse
    '{1, 7, 5,   2, 0, 0, 3},  // R3 sliver between edges is missed
    '{1, 3, 5,  40, 2, 3, 2},  // R2 two sampling edges covered
    '{1, 2, 2,  60, 3, 3, 2},  // R2 three sampling edges covered
    '{0, 7, 8, 150, 1, 3, 5},  // R5 very long pulse
    '{1, 0, 8,   3, 1, 3, 2},  // R2 short pulse straddling one edge
    '{0, 6, 1,  19, 1, 3, 4}   // R4 pulse just under a period
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           mode = 1'b0;
  logic [NCH-1:0] comp = '0;
  logic [NCH-1:0] hit;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hit_detect #(.N_CH(NCH), .SYNC_STAGES(2)) i_hit_detect (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .comp (comp),
    .hit  (hit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Applies one pulse and watches 12 samples taken at falling edges.
  task automatic run_pulse(input int md, input int ch, input int off, input int w,
                           input int exp_cnt, input int exp_first, input string req);
    int cnt = 0;
    int first = 0;
    int other = 0;
    mode = md[0];
    repeat (6) @(negedge clk);
    fork
      begin
        #(off);
        comp[ch] = 1'b1;
        #(w);
        comp[ch] = 1'b0;
      end
      begin
        for (int n = 1; n <= 12; n++) begin
          @(negedge clk);
          if (hit[ch]) begin
            cnt++;
            if (first == 0) first = n;
          end
          if ((hit & ~(NCH'(1) << ch)) != '0) other++;
        end
      end
    join
    check(cnt == exp_cnt, {req, " hit count"}, cnt, exp_cnt);
    check(first == exp_first, {req, " first hit sample"}, first, exp_first);
    check(other == 0, {req, " R6 other channels quiet"}, other, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int cnt;
    int word;
    // R1: reset, with comparator activity during reset
    repeat (2) @(negedge clk);
    comp = 8'hA5;
    @(negedge clk);
    comp = '0;
    repeat (2) @(negedge clk);
    check(hit == '0, "R1 during reset", int'(hit), 0);
    rst = 1'b0;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      check(hit == '0, "R1 after reset", int'(hit), 0);
    end

    // Table walk
    for (int v = 0; v < NV; v++) begin
      run_pulse(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5],
                $sformatf("R%0d vec%0d", VEC[v][6], v));
    end

    // R6: all channels at once in single-shot mode
    mode = 1'b0;
    repeat (6) @(negedge clk);
    #4 comp = '1;
    #2 comp = '0;
    @(negedge clk);
    @(negedge clk);
    check(hit == '0, "R6 all channels before hit", int'(hit), 0);
    @(negedge clk);
    check(hit == '1, "R6 all channels hit together", int'(hit), 255);
    @(negedge clk);
    check(hit == '0, "R6 all channels single cycle", int'(hit), 0);
    repeat (6) @(negedge clk);

    // R8: two pulses on one channel 8 cycles apart
    cnt = 0;
    fork
      begin
        #5 comp[2] = 1'b1;
        #3 comp[2] = 1'b0;
        #157 comp[2] = 1'b1;
        #3 comp[2] = 1'b0;
      end
      begin
        for (int n = 0; n < 20; n++) begin
          @(negedge clk);
          if (hit[2]) cnt++;
        end
      end
    join
    check(cnt == 2, "R8 repeated pulses", cnt, 2);
    repeat (4) @(negedge clk);

    // R7: mode change with a capture pending
    #5 comp[1] = 1'b1;
    #2 comp[1] = 1'b0;
    @(negedge clk);
    mode = 1'b1;
    repeat (3) @(negedge clk);
    mode = 1'b0;
    cnt = 0;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (hit != '0) cnt++;
    end
    check(cnt == 0, "R7 no stale hit after mode change", cnt, 0);
    run_pulse(0, 1, 5, 2, 1, 3, "R7 channel still captures");

    // R5: long held pulse gives no later hit
    #3 comp[4] = 1'b1;
    cnt = 0;
    word = 0;
    for (int n = 0; n < 15; n++) begin
      @(negedge clk);
      if (hit[4]) cnt++;
    end
    check(cnt == 1, "R5 held input one hit", cnt, 1);
    comp[4] = 1'b0;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      if (hit[4]) word++;
    end
    check(word == 0, "R5 release gives no hit", word, 0);

    finish_run();
  end
endmodule